// File: doc/BRIEF.md
# Seven-Level Staircase Modulator with Floating-Cell Balancing

This block is the switching controller for a phase leg built from two cascaded H-bridge cells. One cell is powered from a fixed DC source. The other runs from a floating capacitor whose nominal voltage is half the source voltage. Together the two cells can produce seven equally spaced phase levels, from -3 to +3 half-source steps. A 16-bit angle accumulator advances on each control tick, and three switching angles place the steps of a quarter-wave-symmetric staircase. Each level is translated into a three-state command for the source bridge and one for the capacitor bridge.

The half-step level (plus or minus one half-source step) can be produced by two redundant bridge combinations. The block picks between them using the sign of the load current and a comparator bit that reports whether the capacitor is below its target, so the capacitor is charged or discharged as needed. The choice is frozen when each half-step interval begins. Three phases are produced from one accumulator, at offsets of one third and two thirds of a turn. The ticks come from outside the block, and the angles, the frequency step and the enable are held in registers outside it.

Top module: `staircase_bal_mod`

## Requirements
- R1: After a synchronous active-low reset, every bridge command is zero (code 2'b00) and every reported level is 0.
- R2: While `enable` is low, the angle accumulator is cleared to 0 and every command and level output is zero at the next clock.
- R3: While enabled, the 16-bit accumulator adds `freq_inc` modulo 65536 on each clock where `tick` is high, and holds its value on other clocks.
- R4: Phase 0 uses the accumulator angle. Phase 1 adds 21845 and phase 2 adds 43691, both modulo 65536.
- R5: For angle a, the level sign is negative when a[15] is set. With p = a mod 32768 and q = p when p < 16384, otherwise q = 32768 - p, the magnitude is the number of `ang1`, `ang2`, `ang3` that are less than or equal to q.
- R6: Commands use 2'b00 = zero, 2'b01 = positive, 2'b10 = negative. Level 0 gives source zero and capacitor zero. Levels ±2 give the source bridge at that sign and the capacitor bridge at zero. Levels ±3 give both bridges at that sign.
- R7: At entry to a +1 interval, the block uses source positive with capacitor negative when (current positive) XOR (capacitor low) is 0, and source zero with capacitor positive otherwise.
- R8: At entry to a -1 interval, the rule is the polarity mirror of R7. The block uses source negative with capacitor positive when (current negative) XOR (capacitor low) is 0, and source zero with capacitor negative otherwise.
- R9: Once a half-step interval has started, its bridge combination is held until the level changes, whatever `cur_pos` and `cap_low` do in the meantime.
- R10: Each command and level output reflects the accumulator value from before the most recent clock edge, through exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low clears the angle and zeroes the commands |
| tick | input | 1 | Control-tick strobe that advances the angle |
| freq_inc | input | 16 | Angle increment per tick |
| ang1 | input | 16 | First switching angle (quarter turn = 16384) |
| ang2 | input | 16 | Second switching angle |
| ang3 | input | 16 | Third switching angle |
| cur_pos | input | 3 | Per-phase load current sign, 1 = positive |
| cap_low | input | 3 | Per-phase comparator, 1 = capacitor below target |
| src_cmd | output | 6 | Source-bridge commands, phase k at bits [2k+1:2k] |
| cap_cmd | output | 6 | Capacitor-bridge commands, phase k at bits [2k+1:2k] |
| level | output | 9 | Signed phase level per phase, phase k at bits [3k+2:3k] |

## Verification
The bench goes after the fold point at the quarter turn and the exact angle codes where a step occurs. A design that got the mirror wrong would move the falling steps by one code or leave the negative half out of step with the positive one. It switches the current and comparator inputs at random in every cycle, in the middle of half-step intervals, so a design that re-evaluated the redundant choice inside a step would toggle its bridges there. It would also pick the wrong pair in the negative half if it applied the positive-half rule there. It also covers accumulator wrap with large increments, ticks that arrive only every few cycles, and enable drops during a cycle. A design that kept its old angle or its latched choice across a disable would come back out of phase with the reference.

// File: rtl/stair_pkg.sv
// Shared definitions for the staircase modulator.
// Assumes bridge commands are coded on two bits, with 2'b11 never used.
package stair_pkg;

    typedef enum logic [1:0] {
        BR_ZERO = 2'b00,
        BR_POS  = 2'b01,
        BR_NEG  = 2'b10
    } br_cmd_e;

    // Signed weight of one bridge command: +1, -1 or 0.
    function automatic int br_val(input logic [1:0] c);
        case (c)
            BR_POS:  return 1;
            BR_NEG:  return -1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/stair_phase_acc.sv
// Angle accumulator shared by all phases.
// Adds the increment on each tick while enabled and is cleared while
// disabled. The sum wraps modulo 2**W.
module stair_phase_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] inc,
    output logic [W-1:0] acc
);

    // Advance, hold or clear the electrical angle.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (!en)    acc <= '0;
        else if (tick)   acc <= acc + inc;
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(acc));                               // R3
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc == '0));                                          // R2

endmodule

// File: rtl/stair_level.sv
// Maps an angle word to a signed staircase level from -3 to +3.
// Assumes ang1..ang3 lie within the first quarter turn. The second quarter
// is folded onto the first, and the top bit of the angle gives the sign.
module stair_level #(
    parameter int W = 16
) (
    input  logic [W-1:0]      angle,
    input  logic [W-1:0]      ang1,
    input  logic [W-1:0]      ang2,
    input  logic [W-1:0]      ang3,
    output logic signed [2:0] lvl
);

    localparam logic [W-1:0] HALF_TURN = W'(1) << (W - 1);

    logic [W-1:0] p;
    logic [W-1:0] q;
    logic [1:0]   mag;

    // Fold to the first quarter, count steps passed and apply the sign.
    always_comb begin
        p   = {1'b0, angle[W-2:0]};
        q   = p[W-2] ? (HALF_TURN - p) : p;
        mag = {1'b0, (q >= ang1)} + {1'b0, (q >= ang2)} + {1'b0, (q >= ang3)};
        lvl = angle[W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/stair_cell_map.sv
// Per-phase level-to-bridge mapper with redundant-state selection.
// Assumes the level changes by at most one step per clock. At entry to a
// half-step interval it latches the pair picked from the current sign and
// the capacitor comparator, and holds that pair for the whole interval.
module stair_cell_map
    import stair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic signed [2:0] lvl_in,
    input  logic              cur_pos,
    input  logic              cap_low,
    output logic [1:0]        src_cmd,
    output logic [1:0]        cap_cmd,
    output logic signed [2:0] lvl_out
);

    logic      half_in;
    logic      entry;
    logic      alt_q;
    logic      sel;
    br_cmd_e   src_n;
    br_cmd_e   cap_n;

    // Detect half-step entry and choose the redundant pair.
    always_comb begin
        half_in = (lvl_in == 3'sd1) || (lvl_in == -3'sd1);
        entry   = half_in && (lvl_in != lvl_out);
        sel     = entry ? (cur_pos ^ lvl_in[2] ^ cap_low) : alt_q;
    end

    // Translate the level into the two bridge states.
    always_comb begin
        case (lvl_in)
            3'sd3:   begin src_n = BR_POS;  cap_n = BR_POS;  end
            3'sd2:   begin src_n = BR_POS;  cap_n = BR_ZERO; end
            3'sd1:   begin
                         src_n = sel ? BR_ZERO : BR_POS;
                         cap_n = sel ? BR_POS  : BR_NEG;
                     end
            -3'sd1:  begin
                         src_n = sel ? BR_ZERO : BR_NEG;
                         cap_n = sel ? BR_NEG  : BR_POS;
                     end
            -3'sd2:  begin src_n = BR_NEG;  cap_n = BR_ZERO; end
            -3'sd3:  begin src_n = BR_NEG;  cap_n = BR_NEG;  end
            default: begin src_n = BR_ZERO; cap_n = BR_ZERO; end
        endcase
    end

    // Register the commands, the level and the latched choice.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            src_cmd <= BR_ZERO;
            cap_cmd <= BR_ZERO;
            lvl_out <= '0;
            alt_q   <= 1'b0;
        end else begin
            src_cmd <= src_n;
            cap_cmd <= cap_n;
            lvl_out <= lvl_in;
            if (half_in) alt_q <= sel;
        end
    end

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_cmd != 2'b11) && (cap_cmd != 2'b11));                     // R6
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (2 * br_val(src_cmd) + br_val(cap_cmd)) == int'(lvl_out));     // R6
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (lvl_in == lvl_out) && (lvl_out == 3'sd1 || lvl_out == -3'sd1))
        |=> ($stable(src_cmd) && $stable(cap_cmd)));                   // R9

endmodule

// File: rtl/staircase_bal_mod.sv
// Three-phase seven-level staircase modulator for two-cell cascaded legs.
// One accumulator feeds NPH phases at equal angle offsets. Each phase has
// its own level decoder and balancing mapper. Dead time is added downstream.
module staircase_bal_mod #(
    parameter int W   = 16,
    parameter int NPH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [W-1:0]     freq_inc,
    input  logic [W-1:0]     ang1,
    input  logic [W-1:0]     ang2,
    input  logic [W-1:0]     ang3,
    input  logic [NPH-1:0]   cur_pos,
    input  logic [NPH-1:0]   cap_low,
    output logic [2*NPH-1:0] src_cmd,
    output logic [2*NPH-1:0] cap_cmd,
    output logic [3*NPH-1:0] level
);

    localparam longint FULL_TURN = longint'(1) << W;

    logic [W-1:0] acc;

    stair_phase_acc #(.W(W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (enable),
        .tick  (tick),
        .inc   (freq_inc),
        .acc   (acc)
    );

    for (genvar k = 0; k < NPH; k++) begin : g_phase
        localparam longint       OFF_L = (k * FULL_TURN + NPH / 2) / NPH;
        localparam logic [W-1:0] OFF_K = OFF_L[W-1:0];

        logic [W-1:0]      ang_k;
        logic signed [2:0] lvl_k;
        logic signed [2:0] lvl_q;

        assign ang_k = acc + OFF_K;

        stair_level #(.W(W)) u_lvl (
            .angle (ang_k),
            .ang1  (ang1),
            .ang2  (ang2),
            .ang3  (ang3),
            .lvl   (lvl_k)
        );

        stair_cell_map u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (enable),
            .lvl_in  (lvl_k),
            .cur_pos (cur_pos[k]),
            .cap_low (cap_low[k]),
            .src_cmd (src_cmd[2*k +: 2]),
            .cap_cmd (cap_cmd[2*k +: 2]),
            .lvl_out (lvl_q)
        );

        assign level[3*k +: 3] = lvl_q;
    end

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((src_cmd == '0) && (cap_cmd == '0) && (level == '0))); // R2

endmodule

// File: tb/staircase_bal_mod_bench.sv
`timescale 1ns/1ps
module staircase_bal_mod_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] freq_inc = '0;
    logic [15:0] ang1 = 16'd2000;
    logic [15:0] ang2 = 16'd6000;
    logic [15:0] ang3 = 16'd11000;
    logic [2:0]  cur_pos = '0;
    logic [2:0]  cap_low = '0;
    logic [5:0]  src_cmd;
    logic [5:0]  cap_cmd;
    logic [8:0]  level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_div = 1;
    bit randomize_in = 1'b1;

    int    acc_m = 0;
    int    lvl_m [3];
    bit    alt_m [3];
    int    es_m  [3];
    int    ec_m  [3];
    string tag_m [3];
    int    offs  [3] = '{0, 21845, 43691};

    staircase_bal_mod u_staircase_bal_mod (
        .clk (clk), .rst_n (rst_n), .enable (enable), .tick (tick),
        .freq_inc (freq_inc), .ang1 (ang1), .ang2 (ang2), .ang3 (ang3),
        .cur_pos (cur_pos), .cap_low (cap_low),
        .src_cmd (src_cmd), .cap_cmd (cap_cmd), .level (level)
    );

    always #2 clk = ~clk;

    function automatic int lvl_f(input int a);
        int p, q, m;
        p = a % 32768;
        q = (p >= 16384) ? 32768 - p : p;
        m = 0;
        if (q >= int'(ang1)) m++;
        if (q >= int'(ang2)) m++;
        if (q >= int'(ang3)) m++;
        return (a >= 32768) ? -m : m;
    endfunction

    function automatic int dec(input logic [1:0] c);
        case (c)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b10:   return -1;
            default: return 99;
        endcase
    endfunction

    // Reference model: advances on every rising edge from the bench inputs.
    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            acc_m = 0;
            foreach (lvl_m[k]) begin
                lvl_m[k] = 0; alt_m[k] = 0; es_m[k] = 0; ec_m[k] = 0;
                tag_m[k] = rst_n ? "R2" : "R1";
            end
        end else begin
            for (int k = 0; k < 3; k++) begin
                int l;
                l = lvl_f((acc_m + offs[k]) % 65536);
                if ((l == 1 || l == -1) && l != lvl_m[k])
                    alt_m[k] = cur_pos[k] ^ (l < 0) ^ cap_low[k];
                case (l)
                    3:  begin es_m[k] = 1;  ec_m[k] = 1;  end
                    2:  begin es_m[k] = 1;  ec_m[k] = 0;  end
                    1:  begin es_m[k] = alt_m[k] ? 0 : 1;   ec_m[k] = alt_m[k] ? 1 : -1; end
                    -1: begin es_m[k] = alt_m[k] ? 0 : -1;  ec_m[k] = alt_m[k] ? -1 : 1; end
                    -2: begin es_m[k] = -1; ec_m[k] = 0;  end
                    -3: begin es_m[k] = -1; ec_m[k] = -1; end
                    default: begin es_m[k] = 0; ec_m[k] = 0; end
                endcase
                if (l == 1)       tag_m[k] = "R7 R9";
                else if (l == -1) tag_m[k] = "R8 R9";
                else              tag_m[k] = "R3 R4 R5 R6 R10";
                lvl_m[k] = l;
            end
            if (tick) acc_m = (acc_m + int'(freq_inc)) % 65536;
        end
    end

    // Compare every phase against the model on every falling edge.
    always @(negedge clk) begin
        cycles++;
        for (int k = 0; k < 3; k++) begin
            int al, as_, ac;
            al  = int'($signed(level[3*k +: 3]));
            as_ = dec(src_cmd[2*k +: 2]);
            ac  = dec(cap_cmd[2*k +: 2]);
            checks++;
            if (al != lvl_m[k] || as_ != es_m[k] || ac != ec_m[k]) begin
                errors++;
                $display("FAIL %s phase %0d lvl/src/cap actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         tag_m[k], k, al, as_, ac, lvl_m[k], es_m[k], ec_m[k]);
            end
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = ((i % tick_div) == 0);
            if (randomize_in) begin
                cur_pos = 3'($urandom);
                cap_low = 3'($urandom);
            end
        end
    endtask

    task automatic direct(input string tag, input int k, input int el, input int es, input int ec);
        int al, as_, ac;
        al  = int'($signed(level[3*k +: 3]));
        as_ = dec(src_cmd[2*k +: 2]);
        ac  = dec(cap_cmd[2*k +: 2]);
        checks++;
        if (al != el || as_ != es || ac != ec) begin
            errors++;
            $display("FAIL %s phase %0d lvl/src/cap actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, k, al, as_, ac, el, es, ec);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        for (int k = 0; k < 3; k++) direct("R1", k, 0, 0, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        freq_inc = 16'd0;
        repeat (3) @(negedge clk);
        // R4: offsets 21845 and 43691 fold to q = 10923, which is two steps.
        direct("R4", 0, 0, 0, 0);
        direct("R4", 1, 2, 1, 0);
        direct("R4", 2, -2, -1, 0);
        freq_inc = 16'd300;
        tick_div = 1;
        run(2000);
        freq_inc = 16'd1000;
        tick_div = 3;
        run(2000);
        @(negedge clk);
        enable = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) direct("R2", k, 0, 0, 0);
        enable = 1'b1;
        freq_inc = 16'd77;
        tick_div = 1;
        randomize_in = 1'b0;
        cur_pos = 3'b101;
        cap_low = 3'b011;
        run(1800);
        randomize_in = 1'b1;
        run(1800);
        ang1 = 16'd500;
        ang2 = 16'd8000;
        ang3 = 16'd16384;
        freq_inc = 16'd40000;
        run(600);
        freq_inc = 16'd1;
        run(400);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule